// File: doc/BRIEF.md
# PHY Management Bus Master

This block drives the two-wire management bus toward one or more Ethernet PHYs. It accepts a single register access on a valid/ready request channel, derives the management clock from the system clock, shifts out a frame of preamble, start, opcode, PHY address, register address, turnaround and data, and, for a read, captures the 16 bits the PHY returns. Completion is signalled by a one-cycle done pulse, with read data presented alongside it.

Each request selects either the classic frame or the indirect frame. In the indirect frame a register access takes two transactions: an address transaction, then a data transaction. The data line is modelled as three pad-side signals: output value, output enable and input. It is released whenever the block is idle, and also during the turnaround and data bits of a read.

The request channel applies back-pressure through `req_ready`, which is low for the whole of a transaction. The request fields are captured on the single edge where `req_valid` and `req_ready` are both high, and may change freely at any other time. The completion output has no back-pressure: `done` is a one-cycle pulse, and `rdata` then holds its value until the next read completes.

Top module: `mgmt_bus_master`

## Requirements
- R1: Unless `cfg_skip_pre` is set when the request is accepted, every frame begins with 32 one bits. These are the first 32 of 64 bit times.
- R2: After the preamble come these fields, in this order and each most significant bit first: start (2 bits), opcode (2 bits), PHY address (5 bits), register address (5 bits), turnaround (2 bits) and data (16 bits). With `req_indirect`=0 the start field is 01.
- R3: With `req_indirect`=1 the start field is 00 and the register-address field carries `req_reg`, which serves as a device identifier. The opcode is sent unchanged. Opcode 00 (address) and opcode 01 (write) both drive `req_wdata` in the data field. Opcodes 11 and 10 are reads. In classic frames only opcode 10 is a read, and every other opcode drives `req_wdata`.
- R4: The management clock idles low. Each transaction latches a half period of H = max(`cfg_half_div`, MIN_HALF) system cycles. MIN_HALF is ceil(SYS_CLK_HZ / (2 * MDC_MAX_HZ)), which is 10 at the default settings, so the period is never shorter than 400 ns. Each bit lasts 2H cycles, low phase first.
- R5: `mdio_o` and `mdio_oe` change only where the management clock falls or a frame begins. They never change at a rising edge, nor in the cycle that follows it.
- R6: On frames that drive the data field, the turnaround is driven as 1 and then 0. On reads, `mdio_oe` is low from the first turnaround bit to the end of the frame.
- R7: On reads, each data bit is captured from `mdio_i` in the last system cycle of the low phase just before its rising edge. `rdata` takes the 16 captured bits at `done`. Frames that drive the data field leave `rdata` unchanged.
- R8: `req_ready` is the inverse of busy. A request is accepted on an edge where `req_valid` and `req_ready` are both high. Requests made while busy are ignored. `done` pulses for one cycle exactly N*2H cycles after the accepting edge, where N is the frame length in bits.
- R9: With `cfg_skip_pre` set the preamble is omitted, and the 32-bit frame starts directly with the start field.
- R10: After reset, between transactions and in the cycle `done` is high, `mdio_oe` and `mdc` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_half_div | input | 8 | Requested half period of the management clock, in system cycles |
| cfg_skip_pre | input | 1 | Omit the preamble |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, so a request can be accepted |
| req_indirect | input | 1 | 1 selects the indirect frame, 0 the classic frame |
| req_op | input | 2 | Opcode field |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address or device identifier |
| req_wdata | input | 16 | Data sent by frames that drive the data field |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input from the pad |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Data from the last completed read |

## Verification
The done pulse is due exactly N*2H system cycles after the accepting edge. The bench counts falling system edges from that edge and compares the count with the value it computes from the latched divider and the preamble setting. Frame bits are recorded one time unit after each rising edge of the management clock. The modelled PHY changes `mdio_i` 14 cycles after a rising edge, so a design that samples before the end of the low phase picks up the previous bit. `rdata`, the idle line and `req_ready` are checked in the same half cycle in which done is seen high. Requests raised while the block is busy are checked through the frame that is already on the wire.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int PRE_BITS   = 32;
  localparam int ST_W       = 2;
  localparam int OP_W       = 2;
  localparam int PHY_W      = 5;
  localparam int REG_W      = 5;
  localparam int TA_W       = 2;
  localparam int DATA_W     = 16;
  localparam int CTRL_BITS  = ST_W + OP_W + PHY_W + REG_W + TA_W;
  localparam int FRAME_BITS = PRE_BITS + CTRL_BITS + DATA_W;
  localparam int TA_POS     = PRE_BITS + ST_W + OP_W + PHY_W + REG_W;
  localparam int DATA_POS   = TA_POS + TA_W;
  localparam int POS_W      = $clog2(FRAME_BITS);

  typedef struct packed {
    logic              indirect;
    logic [OP_W-1:0]   op;
    logic [PHY_W-1:0]  phy;
    logic [REG_W-1:0]  regad;
    logic [DATA_W-1:0] wdata;
  } mgmt_req_t;

  function automatic logic op_is_read(input logic indirect, input logic [OP_W-1:0] op);
    return indirect ? op[1] : (op == 2'b10);
  endfunction
endpackage

// File: rtl/mgmt_clkgen.sv
module mgmt_clkgen #(
  parameter int DIV_W    = 8,
  parameter int MIN_HALF = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] half_cfg,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  localparam logic [DIV_W-1:0] MIN_H = DIV_W'(MIN_HALF);

  logic [DIV_W-1:0] half_q, cnt_q;
  logic             mdc_q, wrap;

  assign wrap      = run && (cnt_q == half_q - 1'b1);
  assign rise_tick = wrap && !mdc_q;
  assign fall_tick = wrap && mdc_q;
  assign mdc       = mdc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= MIN_H;
      cnt_q  <= '0;
      mdc_q  <= 1'b0;
    end else if (start) begin
      half_q <= (half_cfg < MIN_H) ? MIN_H : half_cfg;
      cnt_q  <= '0;
      mdc_q  <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      mdc_q  <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      mdc_q  <= ~mdc_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  logic [15:0] hi_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_len_q <= '0;
    else if (mdc_q) hi_len_q <= hi_len_q + 1'b1;
    else            hi_len_q <= '0;
  end

  AST_MDC_HIGH_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc_q) |-> hi_len_q >= 16'(MIN_HALF)); // R4
endmodule

// File: rtl/mgmt_frame_ctrl.sv
module mgmt_frame_ctrl
  import mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  mgmt_req_t         req,
  input  logic              skip_pre,
  input  logic              rise_tick,
  input  logic              fall_tick,
  input  logic              mdio_i,
  output logic              start,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  logic                  busy_q, rd_q, done_q;
  logic [POS_W-1:0]      pos_q;
  logic [FRAME_BITS-1:0] sh_q, frame_w;
  logic [DATA_W-1:0]     rx_q, rdata_q;
  logic [ST_W-1:0]       st_w;
  logic                  accept;

  assign accept  = req_valid && !busy_q;
  assign st_w    = req.indirect ? 2'b00 : 2'b01;
  assign frame_w = {{PRE_BITS{1'b1}}, st_w, req.op, req.phy, req.regad, 2'b10, req.wdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
      pos_q   <= '0;
      sh_q    <= '0;
      rx_q    <= '0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q <= 1'b1;
        rd_q   <= op_is_read(req.indirect, req.op);
        sh_q   <= skip_pre ? (frame_w << PRE_BITS) : frame_w;
        pos_q  <= skip_pre ? POS_W'(PRE_BITS) : '0;
      end else if (busy_q) begin
        if (rise_tick && rd_q && pos_q >= POS_W'(DATA_POS))
          rx_q <= {rx_q[DATA_W-2:0], mdio_i};
        if (fall_tick) begin
          if (pos_q == LAST_POS) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            if (rd_q) rdata_q <= rx_q;
          end else begin
            pos_q <= pos_q + 1'b1;
            sh_q  <= sh_q << 1;
          end
        end
      end
    end
  end

  assign req_ready = !busy_q;
  assign start     = accept;
  assign busy      = busy_q;
  assign mdio_oe   = busy_q && !(rd_q && pos_q >= POS_W'(TA_POS));
  assign mdio_o    = mdio_oe && sh_q[FRAME_BITS-1];
  assign done      = done_q;
  assign rdata     = rdata_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R8
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(busy_q)); // R8
endmodule

// File: rtl/mgmt_bus_master.sv
module mgmt_bus_master
  import mgmt_pkg::*;
#(
  parameter int SYS_CLK_HZ = 50_000_000,
  parameter int MDC_MAX_HZ = 2_500_000,
  parameter int DIV_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_half_div,
  input  logic              cfg_skip_pre,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_indirect,
  input  logic [OP_W-1:0]   req_op,
  input  logic [PHY_W-1:0]  req_phy,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);
  localparam int MIN_HALF = (SYS_CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);

  mgmt_req_t req_w;
  logic      start_w, busy_w, rise_w, fall_w;

  assign req_w = '{indirect: req_indirect, op: req_op, phy: req_phy,
                   regad: req_reg, wdata: req_wdata};

  mgmt_clkgen #(.DIV_W(DIV_W), .MIN_HALF(MIN_HALF)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .start(start_w), .run(busy_w),
    .half_cfg(cfg_half_div), .mdc(mdc), .rise_tick(rise_w), .fall_tick(fall_w)
  );

  mgmt_frame_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req(req_w), .skip_pre(cfg_skip_pre), .rise_tick(rise_w), .fall_tick(fall_w),
    .mdio_i(mdio_i), .start(start_w), .busy(busy_w), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .done(done), .rdata(rdata)
  );

  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_w |-> !mdc); // R4
  AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mdio_oe && !mdc); // R10
  AST_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> $stable(mdio_o) && $stable(mdio_oe)); // R5
  AST_STABLE_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |=> $stable(mdio_o) && $stable(mdio_oe)); // R5
endmodule

// File: tb/tb_mgmt_bus_master.sv
module tb_mgmt_bus_master;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [7:0]  cfg_half_div = 8'd10;
  logic        cfg_skip_pre = 1'b0, req_valid = 1'b0, req_indirect = 1'b0;
  logic [1:0]  req_op = '0;
  logic [4:0]  req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic        mdio_i = 1'b1;
  logic        req_ready, mdc, mdio_o, mdio_oe, done;
  logic [15:0] rdata;

  int n_chk = 0, n_bad = 0;
  int rise_cnt = 0, cur_start = 0;
  bit cur_rd = 0, finished = 0;
  logic [15:0] cur_resp = '0, last_rd = '0;
  logic [63:0] obs_o = '0, obs_oe = '0;

  always #10 clk = ~clk;

  mgmt_bus_master dut (
    .clk(clk), .rst_n(rst_n), .cfg_half_div(cfg_half_div), .cfg_skip_pre(cfg_skip_pre),
    .req_valid(req_valid), .req_ready(req_ready), .req_indirect(req_indirect),
    .req_op(req_op), .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
    .done(done), .rdata(rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Bus monitor and PHY model: record at each rise, answer 14 cycles later
  always @(posedge mdc) begin
    int p;
    #1;
    p = cur_start + rise_cnt;
    rise_cnt++;
    if (p < 64) begin
      obs_o[63-p]  = mdio_o;
      obs_oe[63-p] = mdio_oe;
    end
    repeat (14) @(posedge clk);
    #1;
    if (cur_rd && p == 46)                mdio_i = 1'b0;
    else if (cur_rd && p >= 47 && p <= 62) mdio_i = cur_resp[62-p];
    else                                   mdio_i = 1'b1;
  end

  function automatic logic [63:0] exp_frame(input bit ind, input logic [1:0] op,
      input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd);
    return {32'hFFFF_FFFF, ind ? 2'b00 : 2'b01, op, phy, rg, 2'b10, wd};
  endfunction

  function automatic bit exp_read(input bit ind, input logic [1:0] op);
    return ind ? op[1] : (op == 2'b10);
  endfunction

  task automatic xfer(input bit ind, input logic [1:0] op, input logic [4:0] phy,
      input logic [4:0] rg, input logic [15:0] wd, input logic [7:0] hcfg,
      input bit skip, input bit poke_busy);
    int cyc, he, nb;
    bit rd;
    logic [63:0] ef, eoe, rec;
    rd = exp_read(ind, op);
    he = (hcfg < 8'd10) ? 10 : int'(hcfg);
    nb = skip ? 32 : 64;
    ef = exp_frame(ind, op, phy, rg, wd);
    eoe = rd ? {{46{1'b1}}, 18'b0} : {64{1'b1}};
    rec = skip ? {32'b0, {32{1'b1}}} : {64{1'b1}};
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cfg_half_div = hcfg; cfg_skip_pre = skip;
    req_indirect = ind; req_op = op; req_phy = phy; req_reg = rg; req_wdata = wd;
    cur_rd = rd; cur_resp = 16'($urandom); cur_start = skip ? 32 : 0;
    rise_cnt = 0; obs_o = '0; obs_oe = '0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (poke_busy && cyc == 50) begin
        req_valid = 1'b1; req_phy = ~phy; req_wdata = ~wd; req_op = ~op; cfg_half_div = 8'd40;
      end
      if (poke_busy && cyc == 51) req_valid = 1'b0;
    end
    chk(cyc == nb * 2 * he, "R8/R4 done latency", 64'(cyc), 64'(nb * 2 * he));
    chk((obs_oe & rec) == (eoe & rec), "R6 output enable per bit", obs_oe & rec, eoe & rec);
    chk((obs_o & rec & eoe) == (ef & rec & eoe),
        skip ? "R9 frame bits" : (ind ? "R3 frame bits" : "R2 frame bits"),
        obs_o & rec & eoe, ef & rec & eoe);
    if (!skip)
      chk(obs_o[63:32] == 32'hFFFF_FFFF, "R1 preamble", 64'(obs_o[63:32]), 64'hFFFF_FFFF);
    if (rd) begin
      chk(rdata == cur_resp, "R7 read data", 64'(rdata), 64'(cur_resp));
      last_rd = cur_resp;
    end else begin
      chk(rdata == last_rd, "R7 rdata kept on write", 64'(rdata), 64'(last_rd));
    end
    chk(!mdio_oe && !mdc && req_ready, "R10 released at done",
        64'({mdio_oe, mdc, req_ready}), 64'b001);
    if (poke_busy) chk(1'b1 && !req_valid, "R8 busy request ignored", 0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int unsigned s;
    s = $urandom(32'd20240);
    repeat (3) @(negedge clk);
    chk(!mdc && !mdio_oe && !done && req_ready && rdata == 16'h0, "R10 reset state",
        64'({mdc, mdio_oe, done, req_ready, rdata}), 64'({4'b0001, 16'h0}));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mdc && !mdio_oe, "R4 idle clock low", 64'({mdc, mdio_oe}), 64'b00);
    xfer(1'b0, 2'b01, 5'h11, 5'h04, 16'hA5C3, 8'd10, 1'b0, 1'b0); // classic write
    xfer(1'b0, 2'b10, 5'h1F, 5'h1F, 16'h0000, 8'd10, 1'b0, 1'b0); // classic read
    xfer(1'b1, 2'b00, 5'h02, 5'h07, 16'h8001, 8'd12, 1'b0, 1'b0); // indirect address
    xfer(1'b1, 2'b11, 5'h02, 5'h07, 16'hFFFF, 8'd10, 1'b0, 1'b0); // indirect read
    xfer(1'b1, 2'b10, 5'h00, 5'h01, 16'h1234, 8'd3,  1'b0, 1'b0); // read-inc, divider floor
    xfer(1'b1, 2'b01, 5'h03, 5'h1E, 16'h5A5A, 8'd0,  1'b1, 1'b0); // write, no preamble
    xfer(1'b0, 2'b10, 5'h05, 5'h02, 16'h0000, 8'd11, 1'b1, 1'b1); // read, busy poke
    for (int i = 0; i < 30; i++)
      xfer(1'($urandom), 2'($urandom), 5'($urandom), 5'($urandom), 16'($urandom),
           8'($urandom_range(0, 15)), ($urandom_range(0, 3) == 0), 1'b0);
    repeat (5) @(negedge clk);
    chk(!mdc && !mdio_oe && req_ready, "R10 idle between transactions",
        64'({mdc, mdio_oe, req_ready}), 64'b001);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule